// File: doc/BRIEF.md
# Packet Timestamp Capture Latch

This block records the free-running clock time when a transmit or receive event occurs. Each direction has one slot. The slot holds the captured 64-bit time as a low and a high 32-bit word, with a valid flag. Once a slot has captured a value, it locks. It re-arms only when software reads its high word, so an unread stamp is never overwritten by hardware.

Each direction has its own enable. The transmit side can raise a level interrupt while a stamp is waiting.

For receive there is also a per-packet mode. In this mode every enabled receive event is packed into a 16-byte prefix, which travels with the frame. The prefix holds little-endian dwords: two reserved zero dwords, then the low time word, then the high time word.

Each slot is a small state machine with two states:
- SLOT_ARMED waits for an enabled event. The transition CAPTURE samples the time and moves the slot to SLOT_HELD.
- SLOT_HELD keeps its stamp. The transition RELEASE, a high-word read with no enabled event in the same cycle, returns the slot to SLOT_ARMED. The transition RECAPTURE, a high-word read together with an enabled event, samples the new time and stays in SLOT_HELD.

Top module: `ts_latch`

## Requirements
- R1: In SLOT_ARMED, an enabled event samples `time_now` on that clock edge. Bits 31:0 go to the low-word output and bits 63:32 go to the high-word output. The direction's valid output is 1 after that edge.
- R2: While a slot is valid, further events in that direction do not change its stamp words or its valid flag, unless a high-word read happens in the same cycle.
- R3: A high-word read of a valid slot clears its valid output after that edge. The stamp words keep their last values. A read of an armed slot has no effect.
- R4: While a direction's enable input is 0, its events do not capture.
- R5: `tx_irq` is 1 exactly when the transmit slot is valid and `tx_irq_unmask` is 1. It is a level output and falls on the edge that releases the slot.
- R6: A high-word read and an enabled event in the same cycle capture the new time, and the slot stays valid.
- R7: With `rx_pkt_mode`=1, each enabled receive event loads `rx_pfx` on that edge, whether or not the receive slot is locked. `rx_pfx_vld` is 1 for the following cycle only. The dwords of `rx_pfx` are bits 31:0 = 0, bits 63:32 = 0, bits 95:64 = time low word, and bits 127:96 = time high word.
- R8: After reset, both valid outputs, `tx_irq` and `rx_pfx_vld` are 0, and all stamp words and `rx_pfx` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| time_now | input | 64 | Current clock time |
| tx_evt | input | 1 | Transmit event strobe |
| rx_evt | input | 1 | Receive event strobe |
| tx_en | input | 1 | Transmit capture enable |
| rx_en | input | 1 | Receive capture enable |
| tx_irq_unmask | input | 1 | Unmasks the transmit stamp interrupt |
| rx_pkt_mode | input | 1 | Enables the per-packet receive prefix |
| tx_rd_hi | input | 1 | Software read of the transmit high word |
| rx_rd_hi | input | 1 | Software read of the receive high word |
| tx_stamp_lo | output | 32 | Transmit stamp low word |
| tx_stamp_hi | output | 32 | Transmit stamp high word |
| tx_valid | output | 1 | Transmit slot holds an unread stamp |
| rx_stamp_lo | output | 32 | Receive stamp low word |
| rx_stamp_hi | output | 32 | Receive stamp high word |
| rx_valid | output | 1 | Receive slot holds an unread stamp |
| tx_irq | output | 1 | Transmit stamp interrupt, level |
| rx_pfx | output | 128 | Per-packet receive prefix |
| rx_pfx_vld | output | 1 | Prefix updated on the previous edge |

## Verification
The bench sends second and third events into a locked slot. A slot that failed to lock would overwrite the first stamp.

It also sends a high-word read in the same cycle as an event. A design that gave priority to the release would drop that event, and one that ignored the read would keep the stale stamp.

Events are driven while the enable is low, to catch a design that captures while disabled. The interrupt is checked while masked, then unmasked, then after the release, to catch an edge-triggered or sticky interrupt.

The prefix is checked dword by dword while the receive slot is locked. This exposes swapped words or a prefix tied to the slot lock.

// File: rtl/ts_latch_pkg.sv
package ts_latch_pkg;
    localparam int TIME_W = 64;
    localparam int WORD_W = 32;

    typedef enum logic {
        SLOT_ARMED = 1'b0,
        SLOT_HELD  = 1'b1
    } slot_state_e;
endpackage

// File: rtl/ts_slot.sv
module ts_slot
    import ts_latch_pkg::*;
#(
    parameter int T_W = TIME_W,
    parameter int W_W = WORD_W
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic [T_W-1:0] time_now,
    input  logic           evt,
    input  logic           en,
    input  logic           rd_hi,
    output logic [W_W-1:0] stamp_lo,
    output logic [W_W-1:0] stamp_hi,
    output logic           valid
);
    slot_state_e     state_q, state_d;
    logic            take;
    logic [T_W-1:0]  stamp_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= SLOT_ARMED;
            stamp_q <= '0;
        end else begin
            state_q <= state_d;
            if (take) stamp_q <= time_now;
        end
    end

    always_comb begin
        state_d = state_q;
        take    = 1'b0;
        unique case (state_q)
            SLOT_ARMED: begin
                if (en && evt) begin
                    take    = 1'b1;
                    state_d = SLOT_HELD;
                end
            end
            SLOT_HELD: begin
                if (rd_hi) begin
                    if (en && evt) begin
                        take    = 1'b1;
                        state_d = SLOT_HELD;
                    end else begin
                        state_d = SLOT_ARMED;
                    end
                end
            end
            default: state_d = SLOT_ARMED;
        endcase
    end

    always_comb begin
        valid    = (state_q == SLOT_HELD);
        stamp_lo = stamp_q[W_W-1:0];
        stamp_hi = stamp_q[2*W_W-1:W_W];
    end
endmodule

// File: rtl/ts_pfx_pack.sv
module ts_pfx_pack
    import ts_latch_pkg::*;
#(
    parameter int T_W = TIME_W,
    parameter int W_W = WORD_W,
    parameter int N_DW = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [T_W-1:0]    time_now,
    input  logic              load,
    output logic [N_DW*W_W-1:0] pfx,
    output logic              pfx_vld
);
    localparam int RSV_DW = N_DW - 2;
    logic [N_DW*W_W-1:0] packed_d;

    for (genvar d = 0; d < N_DW; d++) begin : g_dw
        if (d < RSV_DW) begin : g_rsv
            assign packed_d[d*W_W +: W_W] = '0;
        end else begin : g_time
            assign packed_d[d*W_W +: W_W] = time_now[(d-RSV_DW)*W_W +: W_W];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pfx     <= '0;
            pfx_vld <= 1'b0;
        end else begin
            pfx_vld <= load;
            if (load) pfx <= packed_d;
        end
    end
endmodule

// File: rtl/ts_latch.sv
module ts_latch
    import ts_latch_pkg::*;
#(
    parameter int T_W = TIME_W,
    parameter int W_W = WORD_W,
    parameter int N_DW = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [T_W-1:0]      time_now,
    input  logic                tx_evt,
    input  logic                rx_evt,
    input  logic                tx_en,
    input  logic                rx_en,
    input  logic                tx_irq_unmask,
    input  logic                rx_pkt_mode,
    input  logic                tx_rd_hi,
    input  logic                rx_rd_hi,
    output logic [W_W-1:0]      tx_stamp_lo,
    output logic [W_W-1:0]      tx_stamp_hi,
    output logic                tx_valid,
    output logic [W_W-1:0]      rx_stamp_lo,
    output logic [W_W-1:0]      rx_stamp_hi,
    output logic                rx_valid,
    output logic                tx_irq,
    output logic [N_DW*W_W-1:0] rx_pfx,
    output logic                rx_pfx_vld
);
    ts_slot #(.T_W(T_W), .W_W(W_W)) u_tx (
        .clk(clk), .rst_n(rst_n), .time_now(time_now), .evt(tx_evt),
        .en(tx_en), .rd_hi(tx_rd_hi), .stamp_lo(tx_stamp_lo),
        .stamp_hi(tx_stamp_hi), .valid(tx_valid)
    );

    ts_slot #(.T_W(T_W), .W_W(W_W)) u_rx (
        .clk(clk), .rst_n(rst_n), .time_now(time_now), .evt(rx_evt),
        .en(rx_en), .rd_hi(rx_rd_hi), .stamp_lo(rx_stamp_lo),
        .stamp_hi(rx_stamp_hi), .valid(rx_valid)
    );

    ts_pfx_pack #(.T_W(T_W), .W_W(W_W), .N_DW(N_DW)) u_pfx (
        .clk(clk), .rst_n(rst_n), .time_now(time_now),
        .load(rx_pkt_mode && rx_en && rx_evt),
        .pfx(rx_pfx), .pfx_vld(rx_pfx_vld)
    );

    assign tx_irq = tx_valid && tx_irq_unmask;
endmodule

// File: rtl/ts_latch_chk.sv
module ts_latch_chk (
    input logic         clk,
    input logic         rst_n,
    input logic [63:0]  time_now,
    input logic         tx_evt,
    input logic         rx_evt,
    input logic         tx_en,
    input logic         rx_en,
    input logic         tx_irq_unmask,
    input logic         rx_pkt_mode,
    input logic         tx_rd_hi,
    input logic [31:0]  tx_stamp_lo,
    input logic [31:0]  tx_stamp_hi,
    input logic         tx_valid,
    input logic         tx_irq,
    input logic [127:0] rx_pfx,
    input logic         rx_pfx_vld
);
    assert_capture_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && tx_en && tx_evt) |=> (tx_valid && {tx_stamp_hi, tx_stamp_lo} == $past(time_now)));

    assert_lock_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_rd_hi) |=> (tx_valid && $stable(tx_stamp_lo) && $stable(tx_stamp_hi)));

    assert_release_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_rd_hi && !(tx_en && tx_evt)) |=> !tx_valid);

    assert_disabled_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && !tx_en) |=> !tx_valid);

    assert_irq_level_R5: assert property (@(posedge clk) disable iff (!rst_n)
        tx_irq == (tx_valid && tx_irq_unmask));

    assert_recapture_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_rd_hi && tx_en && tx_evt) |=> (tx_valid && {tx_stamp_hi, tx_stamp_lo} == $past(time_now)));

    assert_prefix_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_pkt_mode && rx_en && rx_evt) |=> (rx_pfx_vld && rx_pfx[127:64] == $past(time_now) && rx_pfx[63:0] == 64'd0));
endmodule

bind ts_latch ts_latch_chk u_chk (
    .clk(clk), .rst_n(rst_n), .time_now(time_now), .tx_evt(tx_evt),
    .rx_evt(rx_evt), .tx_en(tx_en), .rx_en(rx_en),
    .tx_irq_unmask(tx_irq_unmask), .rx_pkt_mode(rx_pkt_mode),
    .tx_rd_hi(tx_rd_hi), .tx_stamp_lo(tx_stamp_lo), .tx_stamp_hi(tx_stamp_hi),
    .tx_valid(tx_valid), .tx_irq(tx_irq), .rx_pfx(rx_pfx), .rx_pfx_vld(rx_pfx_vld)
);

// File: tb/ts_latch_tb.sv
`timescale 1ns/1ps
module ts_latch_tb_top;
    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic [63:0]  time_now = '0;
    logic         tx_evt = 0, rx_evt = 0, tx_en = 0, rx_en = 0;
    logic         tx_irq_unmask = 0, rx_pkt_mode = 0, tx_rd_hi = 0, rx_rd_hi = 0;
    logic [31:0]  tx_stamp_lo, tx_stamp_hi, rx_stamp_lo, rx_stamp_hi;
    logic         tx_valid, rx_valid, tx_irq, rx_pfx_vld;
    logic [127:0] rx_pfx;
    int n_chk = 0, n_bad = 0;
    bit done = 0;

    always #10 clk = ~clk;

    ts_latch dut_i (
        .clk(clk), .rst_n(rst_n), .time_now(time_now), .tx_evt(tx_evt),
        .rx_evt(rx_evt), .tx_en(tx_en), .rx_en(rx_en),
        .tx_irq_unmask(tx_irq_unmask), .rx_pkt_mode(rx_pkt_mode),
        .tx_rd_hi(tx_rd_hi), .rx_rd_hi(rx_rd_hi),
        .tx_stamp_lo(tx_stamp_lo), .tx_stamp_hi(tx_stamp_hi), .tx_valid(tx_valid),
        .rx_stamp_lo(rx_stamp_lo), .rx_stamp_hi(rx_stamp_hi), .rx_valid(rx_valid),
        .tx_irq(tx_irq), .rx_pfx(rx_pfx), .rx_pfx_vld(rx_pfx_vld)
    );

    function automatic logic [63:0] tval(input logic [7:0] t);
        return {24'h0000C3, t, 24'h000010, t};
    endfunction

    function automatic logic [63:0] sval(input logic [7:0] t);
        return (t == 8'd0) ? 64'd0 : tval(t);
    endfunction

    task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic step();
        @(posedge clk);
        @(negedge clk);
    endtask

    // {te, re, tr, rr, ten, ren, t[7:0], exp_tv, exp_rv, exp_ts[7:0], exp_rs[7:0]}
    localparam int NV = 12;
    localparam logic [31:0] VEC [NV] = '{
        {6'b000011, 8'h10, 2'b00, 8'h00, 8'h00}, // idle
        {6'b100011, 8'h20, 2'b10, 8'h20, 8'h00}, // R1 tx capture
        {6'b100011, 8'h30, 2'b10, 8'h20, 8'h00}, // R2 tx locked
        {6'b010011, 8'h40, 2'b11, 8'h20, 8'h40}, // R1 rx capture
        {6'b001011, 8'h50, 2'b01, 8'h20, 8'h40}, // R3 tx release, stamp kept
        {6'b110001, 8'h60, 2'b01, 8'h20, 8'h40}, // R4 tx disabled, R2 rx locked
        {6'b010111, 8'h70, 2'b01, 8'h20, 8'h70}, // R6 rx read + event
        {6'b000111, 8'h80, 2'b00, 8'h20, 8'h70}, // R3 rx release
        {6'b010010, 8'h90, 2'b00, 8'h20, 8'h70}, // R4 rx disabled
        {6'b100011, 8'hA0, 2'b10, 8'hA0, 8'h70}, // R1 tx capture again
        {6'b101011, 8'hB0, 2'b10, 8'hB0, 8'h70}, // R6 tx read + event
        {6'b001011, 8'hC0, 2'b00, 8'hB0, 8'h70}  // R3 tx release
    };

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog actual=running expected=done");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        // R8: reset state
        chk("R8 valids", {tx_valid, rx_valid, tx_irq, rx_pfx_vld}, 0);
        chk("R8 stamps", {tx_stamp_hi, tx_stamp_lo, rx_stamp_hi, rx_stamp_lo}, 0);
        chk("R8 prefix", rx_pfx, 0);
        rst_n = 1'b1;
        step();
        tx_irq_unmask = 1'b1;

        for (int i = 0; i < NV; i++) begin
            logic [31:0] v;
            v = VEC[i];
            {tx_evt, rx_evt, tx_rd_hi, rx_rd_hi, tx_en, rx_en} = v[31:26];
            time_now = tval(v[25:18]);
            step();
            chk("R1/R2/R3/R4/R6 tx_valid", tx_valid, v[17]);
            chk("R1/R2/R3/R4/R6 rx_valid", rx_valid, v[16]);
            chk("R1/R2/R6 tx stamp", {tx_stamp_hi, tx_stamp_lo}, sval(v[15:8]));
            chk("R1/R2/R6 rx stamp", {rx_stamp_hi, rx_stamp_lo}, sval(v[7:0]));
            chk("R5 irq follows tx_valid", tx_irq, v[17]);
        end
        {tx_evt, rx_evt, tx_rd_hi, rx_rd_hi} = '0;

        // R5: masked, then unmasked level, then release
        tx_irq_unmask = 1'b0;
        tx_evt = 1'b1;
        time_now = tval(8'hD0);
        step();
        tx_evt = 1'b0;
        chk("R5 masked irq", {tx_valid, tx_irq}, 2'b10);
        step();
        chk("R5 masked stays low", tx_irq, 1'b0);
        tx_irq_unmask = 1'b1;
        #1;
        chk("R5 unmask raises level", tx_irq, 1'b1);
        step();
        chk("R5 level held", tx_irq, 1'b1);
        tx_rd_hi = 1'b1;
        step();
        tx_rd_hi = 1'b0;
        chk("R5 irq drops on release", {tx_valid, tx_irq}, 2'b00);

        // R7: per-packet prefix, rx slot locked first
        rx_evt = 1'b1;
        time_now = tval(8'h11);
        step();
        rx_pkt_mode = 1'b1;
        time_now = tval(8'h22);
        step();
        rx_evt = 1'b0;
        chk("R7 prefix strobe", rx_pfx_vld, 1'b1);
        chk("R7 reserved dwords", rx_pfx[63:0], 64'd0);
        chk("R7 low word dword2", rx_pfx[95:64], tval(8'h22) >> 0 & 64'hFFFF_FFFF);
        chk("R7 high word dword3", rx_pfx[127:96], tval(8'h22) >> 32);
        chk("R7 slot stays locked", {rx_stamp_hi, rx_stamp_lo}, tval(8'h11));
        step();
        chk("R7 strobe one cycle", rx_pfx_vld, 1'b0);
        chk("R7 prefix held", rx_pfx[127:64], tval(8'h22));

        done = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule